// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block moves received frames from a byte stream into memory buffers. The buffers are described by a ring of two-word descriptors. Word 0 of each descriptor holds a buffer address in bits 31:2, a last-entry flag in bit 1 and an ownership flag in bit 0. Word 1 receives a status word that the block writes. A frame arriving on the byte stream starts a fetch of the current descriptor. If the upstream filter accepts the frame, its bytes are packed little-endian and written out as two-word bursts. Every buffer holds 128 bytes, and a long frame continues into the following descriptors. Each buffer that is finished gets its status word and then its ownership flag.

The ring position is an 11-bit word counter added to a programmed list base. The sum is always visible on a readback port. Software programs the base and the per-frame options (start offset, large-frame length mode). It then hands descriptors to the block by clearing their ownership flags. It reads results back by scanning for set ownership flags and the start and end markers.

Top module: `rxring_mgr`

## Requirements
- R1: Out of reset the pointer reads zero, no memory request is raised, no buffer-unavailable pulse is given, and the stream is accepted while no start byte is presented.
- R2: A frame start reads descriptor word 0 at the current pointer. After a buffer is finished, that word is written back with bit 0 set and bits 31:1 unchanged.
- R3: Frame bytes are stored little-endian from the buffer address, plus the configured offset in the frame's first buffer only. Memory writes are issued as two-word bursts to consecutive word addresses, and a request holds its address until acknowledged.
- R4: The status word at pointer+4 carries bit 15 for end of frame, bit 14 for start of frame and bits 11:0 for the frame byte count. Bits 13:12 hold the configured offset when large-frame mode is off.
- R5: With large-frame mode on, status bits 13:12 carry bits 13:12 of the byte count in the end buffer, and zero in other buffers.
- R6: The tag-present flag (bit 21), tag priority (bits 19:17) and tag CFI (bit 16) are written only in an end buffer of a frame marked as tagged. Otherwise they are zero.
- R7: A frame needing more than one buffer sets start only in its first buffer and sets end and length only in its last buffer. Intermediate status bits 11:0 are zero.
- R8: After a buffer is finished, the pointer moves 8 bytes forward, or returns to the base if that descriptor had bit 1 set.
- R9: After 1024 descriptors without a last-entry flag, the pointer returns to the base.
- R10: An error flagged with the end byte leaves the current buffer's descriptor unowned and the pointer on it. Buffers already finished for that frame stay owned.
- R11: A fetched descriptor with bit 0 already set gives a one-cycle buffer-unavailable pulse. The frame is then dropped without writes and the pointer does not move.
- R12: A frame not accepted by the filter causes no memory writes and leaves the pointer unchanged.
- R13: Writing the base resets the ring counter, so the pointer reads the new base.
- R14: While receive is disabled, incoming frames are consumed and discarded without memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_jumbo | input | 1 | Large-frame length mode |
| cfg_offset | input | 2 | Byte offset of data in a frame's first buffer |
| cfg_base_we | input | 1 | Load strobe for the descriptor list base |
| cfg_base | input | 32 | Descriptor list base (word aligned) |
| rd_ptr | output | 32 | Address of the descriptor currently in use |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte taken this cycle when valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame is in error (qualified by in_eof) |
| in_accept | input | 1 | Filter accepts the frame (sampled with the start byte) |
| in_vlan | input | 1 | Frame carries a tag (sampled with the start byte) |
| in_prio | input | 3 | Tag priority |
| in_cfi | input | 1 | Tag CFI bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes on this edge |
| bna_pulse | output | 1 | One-cycle buffer-unavailable indication |

## Verification
in_ready is combinational, so a byte offered at a falling edge is taken at the next rising edge. The buffer-unavailable pulse appears in the cycle after the descriptor read is acknowledged. The pointer moves in the cycle after the ownership write is acknowledged. The base readback changes one cycle after the load strobe. The memory stalls one cycle in four, so the descriptor, data and status writes of a frame finish within a bounded number of cycles after its end byte. The bench therefore waits a fixed 40-cycle quiet window after each frame before reading memory, the pointer and the pulse counter. Everything is sampled at falling edges.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int LEN_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_COLLECT,
    ST_BURST_LO,
    ST_BURST_HI,
    ST_STATUS,
    ST_MARK,
    ST_DISCARD
  } rx_state_e;

  typedef struct packed {
    logic             first;
    logic             last;
    logic             jumbo;
    logic [1:0]       offset;
    logic [LEN_W-1:0] len;
    logic             vlan;
    logic [2:0]       prio;
    logic             cfi;
  } stat_in_t;
endpackage

// File: rtl/rxring_pos.sv
module rxring_pos #(
  parameter int CNT_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] base_i,
  input  logic        adv_i,
  input  logic        wrap_i,
  output logic [31:0] ptr_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(2);
  localparam int PAD_W = 32 - CNT_W - 2;

  logic [31:0]      base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      base_d = base_i;
      cnt_d  = '0;
    end else if (adv_i) begin
      cnt_d = wrap_i ? '0 : cnt_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ptr_o = (base_q & 32'hFFFF_FFFC) + {{PAD_W{1'b0}}, cnt_q, 2'b00};

  // R8 and R9: plain step, rolling over after the last of 1024 entries
  assert_ring_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wrap_i && !load_i) |=> (cnt_q == ($past(cnt_q) + STEP)));
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && wrap_i && !load_i) |=> (cnt_q == '0));
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(cnt_q));
  assert_base_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0));
endmodule

// File: rtl/rxring_pack.sv
module rxring_pack #(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 14,
  localparam int POS_W    = $clog2(BUF_BYTES) + 1,
  localparam int GRP_W    = $clog2(BUF_BYTES) - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr_i,
  input  logic             buf_load_i,
  input  logic [1:0]       start_pos_i,
  input  logic             byte_we_i,
  input  logic [7:0]       byte_i,
  input  logic             drain_i,
  output logic [63:0]      data_o,
  output logic [POS_W-1:0] pos_o,
  output logic [LEN_W-1:0] len_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             closes_o
);
  localparam logic [POS_W-1:0] FULL = POS_W'(BUF_BYTES);

  logic [63:0]      data_q, data_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [GRP_W-1:0] grp_q, grp_d;

  always_comb begin
    data_d = data_q;
    if (buf_load_i || drain_i) begin
      data_d = '0;
    end else if (byte_we_i) begin
      for (int lane = 0; lane < 8; lane++) begin
        if (pos_q[2:0] == 3'(lane)) data_d[lane*8 +: 8] = byte_i;
      end
    end
  end

  always_comb begin
    pos_d = pos_q;
    len_d = len_q;
    grp_d = grp_q;
    if (buf_load_i) pos_d = {{(POS_W-2){1'b0}}, start_pos_i};
    else if (byte_we_i) begin
      pos_d = pos_q + POS_W'(1);
      grp_d = pos_q[POS_W-2:3];
    end
    if (frame_clr_i) len_d = '0;
    else if (byte_we_i) len_d = len_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pos_q  <= '0;
      len_q  <= '0;
      grp_q  <= '0;
    end else begin
      data_q <= data_d;
      pos_q  <= pos_d;
      len_q  <= len_d;
      grp_q  <= grp_d;
    end
  end

  assign data_o   = data_q;
  assign pos_o    = pos_q;
  assign len_o    = len_q;
  assign grp_o    = grp_q;
  assign closes_o = (pos_q[2:0] == 3'd7);

  assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we_i |-> (pos_q < FULL));
  assert_pos_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= FULL);
endmodule

// File: rtl/rxring_stat.sv
module rxring_stat
  import rxring_pkg::*;
(
  input  stat_in_t    s_i,
  output logic [31:0] word_o
);
  always_comb begin
    word_o     = '0;
    word_o[15] = s_i.last;
    word_o[14] = s_i.first;
    if (s_i.last) begin
      word_o[11:0] = s_i.len[11:0];
      if (s_i.vlan) begin
        word_o[21]    = 1'b1;
        word_o[19:17] = s_i.prio;
        word_o[16]    = s_i.cfi;
      end
    end
    if (s_i.jumbo) word_o[13:12] = s_i.last ? s_i.len[13:12] : 2'b00;
    else           word_o[13:12] = s_i.offset;
  end
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxring_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int CNT_W     = 11,
  localparam int POS_W    = $clog2(BUF_BYTES) + 1,
  localparam int GRP_W    = $clog2(BUF_BYTES) - 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_rx_en,
  input  logic        cfg_jumbo,
  input  logic [1:0]  cfg_offset,
  input  logic        cfg_base_we,
  input  logic [31:0] cfg_base,
  output logic [31:0] rd_ptr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_err,
  input  logic        in_accept,
  input  logic        in_vlan,
  input  logic [2:0]  in_prio,
  input  logic        in_cfi,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        bna_pulse
);
  localparam logic [POS_W-1:0] FULL = POS_W'(BUF_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  rx_state_e   state_q, state_d;
  logic [31:0] w0_q, w0_d;
  logic        acc_q, acc_d, first_q, first_d, last_q, last_d;
  logic        vlan_q, vlan_d, cfi_q, cfi_d, bna_q, bna_d;
  logic [2:0]  prio_q, prio_d;

  logic             frame_clr, buf_load, byte_we, drain, adv;
  logic [1:0]       start_pos;
  logic [63:0]      pk_data;
  logic [POS_W-1:0] pk_pos;
  logic [LEN_W-1:0] pk_len;
  logic [GRP_W-1:0] pk_grp;
  logic             pk_closes;
  logic [31:0]      desc_ptr, stat_word, burst_addr;
  stat_in_t         stat_in;

  rxring_pos #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_s), .load_i(cfg_base_we), .base_i(cfg_base),
    .adv_i(adv), .wrap_i(w0_q[1]), .ptr_o(desc_ptr)
  );

  rxring_pack #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_s), .frame_clr_i(frame_clr), .buf_load_i(buf_load),
    .start_pos_i(start_pos), .byte_we_i(byte_we), .byte_i(in_data), .drain_i(drain),
    .data_o(pk_data), .pos_o(pk_pos), .len_o(pk_len), .grp_o(pk_grp),
    .closes_o(pk_closes)
  );

  assign stat_in = '{first: first_q, last: last_q, jumbo: cfg_jumbo, offset: cfg_offset,
                     len: pk_len, vlan: vlan_q, prio: prio_q, cfi: cfi_q};

  rxring_stat u_stat (.s_i(stat_in), .word_o(stat_word));

  assign burst_addr = (w0_q & 32'hFFFF_FFFC) + {{(32-GRP_W-3){1'b0}}, pk_grp, 3'b000};
  assign start_pos  = first_q ? cfg_offset : 2'b00;

  always_comb begin
    state_d   = state_q;
    w0_d      = w0_q;
    acc_d     = acc_q;
    first_d   = first_q;
    last_d    = last_q;
    vlan_d    = vlan_q;
    prio_d    = prio_q;
    cfi_d     = cfi_q;
    bna_d     = 1'b0;
    frame_clr = 1'b0;
    buf_load  = 1'b0;
    byte_we   = 1'b0;
    drain     = 1'b0;
    adv       = 1'b0;
    in_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready = !(in_sof && cfg_rx_en);
        if (in_valid && in_sof && cfg_rx_en) begin
          state_d   = ST_FETCH;
          frame_clr = 1'b1;
          acc_d     = in_accept;
          vlan_d    = in_vlan;
          prio_d    = in_prio;
          cfi_d     = in_cfi;
          first_d   = 1'b1;
          last_d    = 1'b0;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          w0_d = mem_rdata;
          if (mem_rdata[0]) begin
            bna_d   = 1'b1;
            state_d = ST_DISCARD;
          end else if (!acc_q) begin
            state_d = ST_DISCARD;
          end else begin
            buf_load = 1'b1;
            state_d  = ST_COLLECT;
          end
        end
      end
      ST_COLLECT: begin
        in_ready = 1'b1;
        if (in_valid) begin
          byte_we = 1'b1;
          if (in_eof) begin
            if (in_err) state_d = ST_IDLE;
            else begin
              last_d  = 1'b1;
              state_d = ST_BURST_LO;
            end
          end else if (pk_closes) begin
            state_d = ST_BURST_LO;
          end
        end
      end
      ST_BURST_LO: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = burst_addr;
        mem_wdata = pk_data[31:0];
        if (mem_ack) state_d = ST_BURST_HI;
      end
      ST_BURST_HI: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = burst_addr + 32'd4;
        mem_wdata = pk_data[63:32];
        if (mem_ack) begin
          drain   = 1'b1;
          state_d = (last_q || pk_pos == FULL) ? ST_STATUS : ST_COLLECT;
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + 32'd4;
        mem_wdata = stat_word;
        if (mem_ack) state_d = ST_MARK;
      end
      ST_MARK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = w0_q | 32'd1;
        if (mem_ack) begin
          adv     = 1'b1;
          first_d = 1'b0;
          state_d = last_q ? ST_IDLE : ST_FETCH;
        end
      end
      ST_DISCARD: begin
        in_ready = 1'b1;
        if (in_valid && in_eof) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      w0_q    <= '0;
      acc_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      vlan_q  <= 1'b0;
      prio_q  <= '0;
      cfi_q   <= 1'b0;
      bna_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      w0_q    <= w0_d;
      acc_q   <= acc_d;
      first_q <= first_d;
      last_q  <= last_d;
      vlan_q  <= vlan_d;
      prio_q  <= prio_d;
      cfi_q   <= cfi_d;
      bna_q   <= bna_d;
    end
  end

  assign bna_pulse = bna_q;
  assign rd_ptr    = desc_ptr;

  assert_bna_single_R11: assert property (@(posedge clk) disable iff (!rst_s)
    bna_pulse |=> !bna_pulse);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_reject_quiet_R12: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && mem_we) |-> acc_q);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE) |-> !mem_req);
  assert_off_nofetch_R14: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE && !cfg_rx_en) |=> (state_q != ST_FETCH));
endmodule

// File: tb/rxring_mgr_test.sv
module rxring_mgr_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_rx_en = 1'b0, cfg_jumbo = 1'b0, cfg_base_we = 1'b0;
  logic [1:0]  cfg_offset = 2'd0;
  logic [31:0] cfg_base = '0;
  logic [31:0] rd_ptr;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0, in_accept = 1'b0;
  logic        in_vlan = 1'b0, in_cfi = 1'b0;
  logic [2:0]  in_prio = '0;
  logic        mem_req, mem_we, mem_ack, bna_pulse;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:4095];
  int cyc = 0;
  int bna_cnt = 0;
  int wr_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  rxring_mgr uut (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_jumbo(cfg_jumbo),
    .cfg_offset(cfg_offset), .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
    .rd_ptr(rd_ptr), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .in_accept(in_accept),
    .in_vlan(in_vlan), .in_prio(in_prio), .in_cfi(in_cfi), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .bna_pulse(bna_pulse)
  );

  assign mem_ack   = mem_req && (cyc[1:0] != 2'd3);
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bna_pulse) bna_cnt <= bna_cnt + 1;
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr[13:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] buf_of(input bit big, input int i);
    return big ? 32'h3000 : 32'h2100 + 32'(i) * 32'h80;
  endfunction

  task automatic init_small();
    for (int i = 0; i < 4; i++) begin
      mem[(32'h2000 >> 2) + 2*i]     = buf_of(0, i) | ((i == 3) ? 32'd2 : 32'd0);
      mem[(32'h2000 >> 2) + 2*i + 1] = '0;
    end
  endtask

  task automatic send_frame(input int n, input int seed, input bit acc, input bit err,
                            input bit vl, input logic [2:0] pr, input bit cf, input int quiet);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(seed + k);
      in_sof = (k == 0); in_eof = (k == n - 1); in_err = err && (k == n - 1);
      in_accept = acc; in_vlan = vl; in_prio = pr; in_cfi = cf;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    repeat (quiet) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input int b, input int nbuf, input int n, input int off,
                                           input bit jb, input bit vl, input logic [2:0] pr, input bit cf);
    logic [31:0] s = '0;
    logic [13:0] nn = 14'(n);
    bit last = (b == nbuf - 1);
    s[14] = (b == 0);
    if (last) begin
      s[15] = 1'b1; s[11:0] = nn[11:0];
      if (vl) begin s[21] = 1'b1; s[19:17] = pr; s[16] = cf; end
    end
    s[13:12] = jb ? (last ? nn[13:12] : 2'b00) : 2'(off);
    return s;
  endfunction

  // data, status and ownership of a completed frame
  task automatic check_frame(input bit big, input logic [31:0] base, input int ringn, input int start,
                             input int n, input int seed, input int off, input bit jb,
                             input bit vl, input logic [2:0] pr, input bit cf);
    int nbuf = (n + off + 127) / 128;
    int bad = 0;
    logic [31:0] a, da, got;
    logic [7:0] bexp, bgot;
    for (int k = 0; k < n; k++) begin
      int p = k + off;
      int di = (start + p / 128) % ringn;
      a = buf_of(big, di) + 32'(p % 128);
      bgot = mem[a[13:2]][8*a[1:0] +: 8];
      bexp = 8'(seed + k);
      if (bgot !== bexp) bad++;
    end
    check(bad == 0, "R3 data bytes", 32'(bad), 32'd0);
    for (int b = 0; b < nbuf; b++) begin
      da = base + 32'((start + b) % ringn) * 32'd8;
      got = mem[da[13:2] + 1];
      check(got === exp_stat(b, nbuf, n, off, jb, vl, pr, cf), "R4/R7 status", got,
            exp_stat(b, nbuf, n, off, jb, vl, pr, cf));
      got = mem[da[13:2]];
      check(got[0] === 1'b1 && (got & 32'hFFFF_FFFC) === buf_of(big, (start + b) % ringn),
            "R2 owned word0", got, buf_of(big, (start + b) % ringn) | 32'd1);
    end
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk); cfg_base = b; cfg_base_we = 1'b1;
    @(negedge clk); cfg_base_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int w, b0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    init_small();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_ptr === 32'h0, "R1 ptr", rd_ptr, 32'h0);
    check(mem_req === 1'b0 && bna_pulse === 1'b0, "R1 idle", {30'd0, mem_req, bna_pulse}, 32'h0);
    check(in_ready === 1'b1, "R1 ready", {31'd0, in_ready}, 32'h1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13: base load
    load_base(32'h2000);
    check(rd_ptr === 32'h2000, "R13 base", rd_ptr, 32'h2000);
    cfg_rx_en = 1'b1;

    // short single-buffer frame
    send_frame(10, 8'h10, 1, 0, 0, 3'd0, 0, 40);
    check_frame(0, 32'h2000, 4, 0, 10, 8'h10, 0, 0, 0, 3'd0, 0);
    check(rd_ptr === 32'h2008, "R8 step", rd_ptr, 32'h2008);

    // R7/R6: two-buffer tagged frame with offset 2
    cfg_offset = 2'd2;
    send_frame(200, 8'h40, 1, 0, 1, 3'd5, 1, 40);
    check_frame(0, 32'h2000, 4, 1, 200, 8'h40, 2, 0, 1, 3'd5, 1);
    check(rd_ptr === 32'h2018, "R7 ptr", rd_ptr, 32'h2018);

    // R10: single-buffer error frame rewinds
    send_frame(20, 8'h70, 1, 1, 0, 3'd0, 0, 40);
    check(mem[(32'h2018 >> 2)][0] === 1'b0, "R10 unowned", mem[32'h2018 >> 2], buf_of(0, 3) | 32'd2);
    check(rd_ptr === 32'h2018, "R10 ptr", rd_ptr, 32'h2018);

    // R5 with offset 3 and wrap at entry 3 (R8)
    cfg_jumbo = 1'b1; cfg_offset = 2'd3;
    send_frame(16, 8'h90, 1, 0, 0, 3'd0, 0, 40);
    check_frame(0, 32'h2000, 4, 3, 16, 8'h90, 3, 1, 0, 3'd0, 0);
    check(rd_ptr === 32'h2000, "R8 wrap", rd_ptr, 32'h2000);

    // R11: entry 0 still owned
    w = wr_cnt; b0 = bna_cnt;
    send_frame(30, 8'hA0, 1, 0, 0, 3'd0, 0, 40);
    check(bna_cnt == b0 + 1, "R11 pulse", 32'(bna_cnt), 32'(b0 + 1));
    check(wr_cnt == w, "R11 no writes", 32'(wr_cnt), 32'(w));
    check(rd_ptr === 32'h2000, "R11 ptr", rd_ptr, 32'h2000);
    check(mem[(32'h2000 >> 2) + 1] === 32'h0000_C00A, "R11 status kept", mem[(32'h2000 >> 2) + 1], 32'h0000_C00A);

    init_small();
    cfg_jumbo = 1'b0; cfg_offset = 2'd0;
    // R12: filter reject
    w = wr_cnt; b0 = bna_cnt;
    send_frame(40, 8'h11, 0, 0, 0, 3'd0, 0, 40);
    check(wr_cnt == w && bna_cnt == b0, "R12 no writes", 32'(wr_cnt), 32'(w));
    check(rd_ptr === 32'h2000, "R12 ptr", rd_ptr, 32'h2000);

    // R14: receive disabled
    cfg_rx_en = 1'b0;
    w = wr_cnt;
    send_frame(12, 8'h22, 1, 0, 0, 3'd0, 0, 40);
    check(wr_cnt == w, "R14 no writes", 32'(wr_cnt), 32'(w));
    check(rd_ptr === 32'h2000, "R14 ptr", rd_ptr, 32'h2000);
    cfg_rx_en = 1'b1;

    // R10: error in the second buffer keeps the first owned
    send_frame(150, 8'h33, 1, 1, 0, 3'd0, 0, 40);
    check(mem[32'h2000 >> 2][0] === 1'b1, "R10 first owned", mem[32'h2000 >> 2], buf_of(0, 0) | 32'd1);
    check(mem[(32'h2000 >> 2) + 1] === 32'h0000_4000, "R10 first status", mem[(32'h2000 >> 2) + 1], 32'h0000_4000);
    check(mem[32'h2008 >> 2][0] === 1'b0, "R10 second unowned", mem[32'h2008 >> 2], buf_of(0, 1));
    check(rd_ptr === 32'h2008, "R10 ptr", rd_ptr, 32'h2008);

    // R13: reloading the base resets the counter
    load_base(32'h2000);
    check(rd_ptr === 32'h2000, "R13 reset", rd_ptr, 32'h2000);

    // R6: tag inputs ignored when the frame is untagged
    init_small();
    send_frame(5, 8'h55, 1, 0, 0, 3'd7, 1, 40);
    check_frame(0, 32'h2000, 4, 0, 5, 8'h55, 0, 0, 0, 3'd0, 0);
    check(mem[(32'h2000 >> 2) + 1][21:16] === 6'd0, "R6 untagged", mem[(32'h2000 >> 2) + 1], 32'h0000_C005);

    // R9: 1024 entries without a last-entry flag
    for (int i = 0; i < 1024; i++) begin
      mem[2*i] = 32'h3000; mem[2*i + 1] = '0;
    end
    load_base(32'h0);
    for (int f = 0; f < 1023; f++) send_frame(1, f, 1, 0, 0, 3'd0, 0, 14);
    repeat (20) @(negedge clk);
    check(rd_ptr === 32'h1FF8, "R9 last entry", rd_ptr, 32'h1FF8);
    send_frame(1, 8'hC7, 1, 0, 0, 3'd0, 0, 40);
    check(rd_ptr === 32'h0, "R9 roll", rd_ptr, 32'h0);
    check_frame(1, 32'h0, 1024, 1023, 1, 8'hC7, 0, 0, 0, 3'd0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule